// File: doc/BRIEF.md
# Page Translation Unit with Hashed Table Walk

This block turns a 32-bit effective address into a 32-bit real address using paged translation. The top four address bits pick one of sixteen segment registers, which supply a 24-bit virtual segment identifier, two privilege keys and a no-execute flag. A 64-entry direct-mapped cache of recent page translations is consulted first. On a miss, a walker reads page-table entries from memory through a one-request-at-a-time word interface. It searches a primary group and then a secondary group, fills the cache from the matching entry and keeps the entry's referenced and changed flags up to date in memory.

A requester presents one translation at a time with a single-cycle `req_valid` pulse and waits for the one-cycle `rsp_done` pulse. That pulse carries either the real address or a fault code. Segment register writes and invalidate commands are given while no translation is in progress.

Bit numbering below uses bit 31 as the most significant. The effective address splits into segment `ea[31:28]`, page index `ea[27:12]` and byte offset `ea[11:0]`.

Top module: `page_xlate`

## Requirements
- R1: After reset `rsp_done` and `mem_req` are low and every cache entry is invalid, so the first translation of any page walks the table.
- R2: A segment register write stores Ks from `seg_data[30]`, Kp from `seg_data[29]`, no-execute from `seg_data[28]` and the VSID from `seg_data[23:0]`. An instruction fetch (`req_acc`=2) through a segment with no-execute set ends with fault 2 (protection) and no memory request. Data accesses through that segment are translated normally.
- R3: The primary group address is formed from a hash: the low 19 VSID bits XOR the zero-extended 16-bit page index. Bits [31:16] of the group address are `cfg_base` ORed with (hash[18:10] AND `cfg_mask`). Bits [15:6] are hash[9:0]. Entry k of the group sits at group+8k, with word 0 first and word 1 at +4.
- R4: Word 0 matches when bit 31 (valid) is 1, bit 6 (hash select) equals the pass number, bits [30:7] equal the VSID and bits [5:0] equal page index bits [15:10]. The eight entries are read in order. If none matches, the secondary pass repeats the search using the one's complement of the hash.
- R5: When neither pass matches, after sixteen word-0 reads the translation ends with fault 1 (table miss).
- R6: On a match, word 1 is read. Its fields are RPN [31:12], referenced [8], changed [7] and PP [1:0]. The cache entry is filled from word 1. If the referenced bit is clear, word 1 is written back with bit 8 set; only word 1 is ever written.
- R7: A cache hit needs the stored VSID and page index to equal the current ones. A hit makes no memory request, and the real address is {RPN, `ea[11:0]`}.
- R8: The key is Kp when `req_user`=1 and Ks otherwise. With key 0, every access is allowed except a write (`req_acc`=1) with PP=3. With key 1, PP=0 denies everything, PP=1 and PP=3 deny writes, and PP=2 allows all. A denied access gives fault 2.
- R9: The first permitted write to a page whose cached changed bit is clear reads word 1 again and writes it back with bit 7 set. Later writes to that page make no memory request.
- R10: `inv_one` invalidates the cache entry indexed by `inv_ea[17:12]`, and `inv_all` invalidates all 64 entries. The next access to an invalidated page walks again.
- R11: A memory request holds its address, data and direction until the cycle in which `mem_rdy` is high. `mem_rdata` is taken in that cycle.
- R12: `rsp_done` is high for exactly one cycle per accepted request. On a fault `rsp_ra` is zero. Fault code 0 means success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| req_valid | input | 1 | start a translation (only while idle) |
| req_ea | input | 32 | effective address |
| req_acc | input | 2 | 0 data read, 1 data write, 2 instruction fetch |
| req_user | input | 1 | 1 problem state, 0 supervisor |
| cfg_base | input | 16 | page table base, real address bits [31:16] |
| cfg_mask | input | 9 | mask on hash bits [18:10] |
| seg_we | input | 1 | segment register write enable |
| seg_idx | input | 4 | segment register number |
| seg_data | input | 32 | segment register value |
| inv_one | input | 1 | invalidate one cache entry |
| inv_ea | input | 32 | address selecting the entry to invalidate |
| inv_all | input | 1 | invalidate every cache entry |
| rsp_done | output | 1 | translation finished (one cycle) |
| rsp_ra | output | 32 | real address |
| rsp_fault | output | 2 | 0 none, 1 table miss, 2 protection |
| mem_req | output | 1 | memory request pending |
| mem_we | output | 1 | request is a write |
| mem_addr | output | 32 | word address of the request |
| mem_wdata | output | 32 | write data |
| mem_rdy | input | 1 | memory accepts/answers this cycle |
| mem_rdata | input | 32 | read data, valid with mem_rdy |

## Verification
The hardest case to reach is a match in the secondary group while the primary group holds an entry that agrees in every field except the hash-select flag. The stimulus places such a decoy in the primary group, with a different RPN, and the page's true entry in secondary slot 0. The hash bits above bit 9 are made non-zero so the mask path changes the group address. The bench then checks the returned address and the exact number of word reads, ten. The changed-bit sequence is reached the same way: a read fills the cache with the changed bit clear, and a write to the same page follows.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

    localparam int EA_W     = 32;
    localparam int VSID_W   = 24;
    localparam int PAGE_W   = 16;
    localparam int OFF_W    = 12;
    localparam int RPN_W    = EA_W - OFF_W;
    localparam int HASH_W   = 19;
    localparam int MASK_W   = 9;
    localparam int SEG_N    = 16;
    localparam int SEG_IW   = $clog2(SEG_N);
    localparam int TLB_N    = 64;
    localparam int TLB_IW   = $clog2(TLB_N);
    localparam int GRP_SLOTS = 8;
    localparam int SLOT_W   = $clog2(GRP_SLOTS);
    localparam int API_W    = 6;
    localparam int BIT_REF  = 8;
    localparam int BIT_CHG  = 7;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_MISS = 2'd1,
        FLT_PROT = 2'd2
    } flt_e;

    typedef struct packed {
        logic              ks;
        logic              kp;
        logic              nx;
        logic [VSID_W-1:0] vsid;
    } seg_t;

    typedef struct packed {
        logic [VSID_W:0]   tag;
        logic [PAGE_W-1:0] page;
        logic [RPN_W-1:0]  rpn;
        logic [1:0]        pp;
        logic              chg;
        logic [EA_W-1:0]   w1_addr;
    } tlb_ent_t;

    function automatic seg_t seg_unpack(input logic [31:0] d);
        seg_t s;
        s.ks   = d[30];
        s.kp   = d[29];
        s.nx   = d[28];
        s.vsid = d[VSID_W-1:0];
        return s;
    endfunction

    function automatic logic [EA_W-1:0] group_addr(
        input logic [15:0]        base,
        input logic [MASK_W-1:0]  mask,
        input logic [VSID_W-1:0]  vsid,
        input logic [PAGE_W-1:0]  page,
        input logic               second);
        logic [HASH_W-1:0] h;
        h = vsid[HASH_W-1:0] ^ {{(HASH_W-PAGE_W){1'b0}}, page};
        if (second) h = ~h;
        return {base | {{(16-MASK_W){1'b0}}, h[HASH_W-1:10] & mask}, h[9:0], 6'b0};
    endfunction

    function automatic logic w0_match(
        input logic [31:0]        w0,
        input logic [VSID_W-1:0]  vsid,
        input logic [PAGE_W-1:0]  page,
        input logic               second);
        return w0[31] && (w0[6] == second) && (w0[30:7] == vsid)
            && (w0[5:0] == page[PAGE_W-1 -: API_W]);
    endfunction

    function automatic logic access_ok(
        input logic       key,
        input logic [1:0] pp,
        input acc_e       acc);
        logic wr;
        wr = (acc == ACC_WRITE);
        if (!key) return !(wr && pp == 2'b11);
        case (pp)
            2'b00:   return 1'b0;
            2'b10:   return 1'b1;
            default: return !wr;
        endcase
    endfunction

endpackage

// File: rtl/pgx_segfile.sv
module pgx_segfile
    import pgx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SEG_IW-1:0] widx,
    input  logic [31:0]       wdata,
    input  logic [SEG_IW-1:0] ridx,
    output seg_t              rd
);
    seg_t regs [SEG_N];

    for (genvar g = 0; g < SEG_N; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (we && widx == SEG_IW'(g))
                regs[g] <= seg_unpack(wdata);
        end
    end

    assign rd = regs[ridx];

endmodule

// File: rtl/pgx_tlb.sv
module pgx_tlb
    import pgx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [TLB_IW-1:0] idx,
    output tlb_ent_t          rd,
    input  logic              fill_we,
    input  tlb_ent_t          fill_ent,
    input  logic              setc_we,
    input  logic              inv_one,
    input  logic [TLB_IW-1:0] inv_idx,
    input  logic              inv_all
);
    localparam logic [VSID_W:0] TAG_DEAD = '1;

    tlb_ent_t ents [TLB_N];

    for (genvar g = 0; g < TLB_N; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst || inv_all || (inv_one && inv_idx == TLB_IW'(g))) begin
                ents[g]     <= '0;
                ents[g].tag <= TAG_DEAD;
            end else if (fill_we && idx == TLB_IW'(g)) begin
                ents[g] <= fill_ent;
            end else if (setc_we && idx == TLB_IW'(g)) begin
                ents[g].chg <= 1'b1;
            end
        end
    end

    assign rd = ents[idx];

    AST_INV_ALL_EMPTY: assert property (@(posedge clk) disable iff (rst)
        inv_all |=> (rd.tag == TAG_DEAD)) else $error("inv_all left a live entry"); // R10

endmodule

// File: rtl/pgx_walker.sv
module pgx_walker
    import pgx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [EA_W-1:0]   req_ea,
    input  acc_e              req_acc,
    input  logic              req_user,
    input  logic [15:0]       cfg_base,
    input  logic [MASK_W-1:0] cfg_mask,
    input  seg_t              seg_rd,
    input  tlb_ent_t          tlb_rd,
    output logic [EA_W-1:0]   cur_ea,
    output logic              fill_we,
    output tlb_ent_t          fill_ent,
    output logic              setc_we,
    output logic              mem_req,
    output logic              mem_we,
    output logic [EA_W-1:0]   mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_rdy,
    input  logic [31:0]       mem_rdata,
    output logic              rsp_done,
    output logic [EA_W-1:0]   rsp_ra,
    output flt_e              rsp_fault
);
    typedef enum logic [3:0] {
        S_IDLE, S_LOOKUP, S_READ_W0, S_CHECK, S_READ_W1,
        S_WRITE_R, S_READ_C, S_SET_C, S_DONE
    } st_e;

    st_e               st;
    logic [EA_W-1:0]   ea_q;
    acc_e              acc_q;
    logic              user_q;
    logic              pass_q;
    logic [SLOT_W-1:0] slot_q;
    logic [31:0]       w0_q, w1_q;
    logic [EA_W-1:0]   ra_q;
    flt_e              flt_q;

    logic [PAGE_W-1:0] page;
    logic [EA_W-1:0]   grp;
    logic [EA_W-1:0]   ent_addr;
    logic              hit, key, perm, xfer;

    assign cur_ea   = ea_q;
    assign page     = ea_q[OFF_W +: PAGE_W];
    assign grp      = group_addr(cfg_base, cfg_mask, seg_rd.vsid, page, pass_q);
    assign ent_addr = grp | {{(EA_W-SLOT_W-3){1'b0}}, slot_q, 3'b000};
    assign hit      = (tlb_rd.tag == {1'b0, seg_rd.vsid}) && (tlb_rd.page == page);
    assign key      = user_q ? seg_rd.kp : seg_rd.ks;
    assign perm     = access_ok(key, tlb_rd.pp, acc_q);
    assign xfer     = mem_req && mem_rdy;

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (st)
            S_READ_W0: begin mem_req = 1'b1; mem_addr = ent_addr; end
            S_READ_W1: begin mem_req = 1'b1; mem_addr = ent_addr | 32'd4; end
            S_WRITE_R: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = ent_addr | 32'd4;
                mem_wdata = w1_q | (32'd1 << BIT_REF);
            end
            S_READ_C:  begin mem_req = 1'b1; mem_addr = tlb_rd.w1_addr; end
            S_SET_C:   begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = tlb_rd.w1_addr;
                mem_wdata = w1_q | (32'd1 << BIT_CHG);
            end
            default: ;
        endcase
    end

    always_comb begin
        fill_ent         = '0;
        fill_ent.tag     = {1'b0, seg_rd.vsid};
        fill_ent.page    = page;
        fill_ent.rpn     = mem_rdata[31 -: RPN_W];
        fill_ent.pp      = mem_rdata[1:0];
        fill_ent.chg     = mem_rdata[BIT_CHG];
        fill_ent.w1_addr = ent_addr | 32'd4;
        fill_we          = (st == S_READ_W1) && xfer;
        setc_we          = (st == S_SET_C) && xfer;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            ea_q   <= '0;
            acc_q  <= ACC_READ;
            user_q <= 1'b0;
            pass_q <= 1'b0;
            slot_q <= '0;
            w0_q   <= '0;
            w1_q   <= '0;
            ra_q   <= '0;
            flt_q  <= FLT_NONE;
        end else begin
            case (st)
                S_IDLE: if (req_valid) begin
                    ea_q   <= req_ea;
                    acc_q  <= req_acc;
                    user_q <= req_user;
                    st     <= S_LOOKUP;
                end
                S_LOOKUP: begin
                    if (acc_q == ACC_FETCH && seg_rd.nx) begin
                        ra_q <= '0; flt_q <= FLT_PROT; st <= S_DONE;
                    end else if (hit) begin
                        if (!perm) begin
                            ra_q <= '0; flt_q <= FLT_PROT; st <= S_DONE;
                        end else if (acc_q == ACC_WRITE && !tlb_rd.chg) begin
                            st <= S_READ_C;
                        end else begin
                            ra_q  <= {tlb_rd.rpn, ea_q[OFF_W-1:0]};
                            flt_q <= FLT_NONE;
                            st    <= S_DONE;
                        end
                    end else begin
                        pass_q <= 1'b0;
                        slot_q <= '0;
                        st     <= S_READ_W0;
                    end
                end
                S_READ_W0: if (xfer) begin
                    w0_q <= mem_rdata;
                    st   <= S_CHECK;
                end
                S_CHECK: begin
                    if (w0_match(w0_q, seg_rd.vsid, page, pass_q)) begin
                        st <= S_READ_W1;
                    end else if (slot_q == SLOT_W'(GRP_SLOTS - 1)) begin
                        if (!pass_q) begin
                            pass_q <= 1'b1;
                            slot_q <= '0;
                            st     <= S_READ_W0;
                        end else begin
                            ra_q <= '0; flt_q <= FLT_MISS; st <= S_DONE;
                        end
                    end else begin
                        slot_q <= slot_q + 1'b1;
                        st     <= S_READ_W0;
                    end
                end
                S_READ_W1: if (xfer) begin
                    w1_q <= mem_rdata;
                    st   <= mem_rdata[BIT_REF] ? S_LOOKUP : S_WRITE_R;
                end
                S_WRITE_R: if (xfer) st <= S_LOOKUP;
                S_READ_C: if (xfer) begin
                    w1_q <= mem_rdata;
                    st   <= S_SET_C;
                end
                S_SET_C: if (xfer) begin
                    ra_q  <= {tlb_rd.rpn, ea_q[OFF_W-1:0]};
                    flt_q <= FLT_NONE;
                    st    <= S_DONE;
                end
                S_DONE:  st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    assign rsp_done  = (st == S_DONE);
    assign rsp_ra    = ra_q;
    assign rsp_fault = flt_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)))
        else $error("memory request dropped or changed"); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done) else $error("done longer than a cycle"); // R12
    AST_FAULT_RA_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && rsp_fault != FLT_NONE) |-> (rsp_ra == '0)) else $error("fault with address"); // R12
    AST_WRITE_WORD1: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_addr[2] && mem_addr[1:0] == 2'b00)) else $error("write not to word 1"); // R6
    AST_NX_NO_MEM: assert property (@(posedge clk) disable iff (rst)
        (st == S_LOOKUP && acc_q == ACC_FETCH && seg_rd.nx) |=> !mem_req) else $error("no-execute fetch reached memory"); // R2

endmodule

// File: rtl/page_xlate.sv
module page_xlate
    import pgx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_ea,
    input  logic [1:0]  req_acc,
    input  logic        req_user,
    input  logic [15:0] cfg_base,
    input  logic [8:0]  cfg_mask,
    input  logic        seg_we,
    input  logic [3:0]  seg_idx,
    input  logic [31:0] seg_data,
    input  logic        inv_one,
    input  logic [31:0] inv_ea,
    input  logic        inv_all,
    output logic        rsp_done,
    output logic [31:0] rsp_ra,
    output logic [1:0]  rsp_fault,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_rdy,
    input  logic [31:0] mem_rdata
);
    seg_t            seg_rd;
    tlb_ent_t        tlb_rd, fill_ent;
    logic            fill_we, setc_we;
    logic [EA_W-1:0] cur_ea;
    flt_e            flt;

    pgx_segfile u_seg (
        .clk   (clk),
        .rst   (rst),
        .we    (seg_we),
        .widx  (seg_idx),
        .wdata (seg_data),
        .ridx  (cur_ea[EA_W-1 -: SEG_IW]),
        .rd    (seg_rd)
    );

    pgx_tlb u_tlb (
        .clk      (clk),
        .rst      (rst),
        .idx      (cur_ea[OFF_W +: TLB_IW]),
        .rd       (tlb_rd),
        .fill_we  (fill_we),
        .fill_ent (fill_ent),
        .setc_we  (setc_we),
        .inv_one  (inv_one),
        .inv_idx  (inv_ea[OFF_W +: TLB_IW]),
        .inv_all  (inv_all)
    );

    pgx_walker u_walk (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ea    (req_ea),
        .req_acc   (acc_e'(req_acc)),
        .req_user  (req_user),
        .cfg_base  (cfg_base),
        .cfg_mask  (cfg_mask),
        .seg_rd    (seg_rd),
        .tlb_rd    (tlb_rd),
        .cur_ea    (cur_ea),
        .fill_we   (fill_we),
        .fill_ent  (fill_ent),
        .setc_we   (setc_we),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdy   (mem_rdy),
        .mem_rdata (mem_rdata),
        .rsp_done  (rsp_done),
        .rsp_ra    (rsp_ra),
        .rsp_fault (flt)
    );

    assign rsp_fault = flt;

endmodule

// File: tb/sim_page_xlate.sv
module sim_page_xlate;
    logic        clk = 0, rst = 1;
    logic        req_valid = 0, req_user = 0;
    logic [31:0] req_ea = 0;
    logic [1:0]  req_acc = 0;
    logic [15:0] cfg_base = 16'h0010;
    logic [8:0]  cfg_mask = 9'h003;
    logic        seg_we = 0;
    logic [3:0]  seg_idx = 0;
    logic [31:0] seg_data = 0;
    logic        inv_one = 0, inv_all = 0;
    logic [31:0] inv_ea = 0;
    logic        rsp_done, mem_req, mem_we;
    logic [31:0] rsp_ra, mem_addr, mem_wdata;
    logic [1:0]  rsp_fault;
    logic        mem_rdy = 0;
    logic [31:0] mem_rdata = 0;

    int errors = 0, checks = 0;
    int rd_cnt = 0, wr_cnt = 0;
    int lat = 0;
    logic [31:0] mem [logic [31:0]];

    typedef struct { logic [31:0] ra; logic [1:0] f; string tag; } exp_t;
    exp_t sbq [$];

    page_xlate u0 (.*);

    always #5 clk = ~clk;

    function automatic logic [31:0] mrd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic void chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endfunction

    // memory model: variable latency, answers with mem_rdy
    always @(posedge clk) begin
        mem_rdy <= 1'b0;
        if (mem_req && mem_rdy) begin
            if (mem_we) begin mem[mem_addr] = mem_wdata; wr_cnt++; end
            else rd_cnt++;
        end else if (mem_req) begin
            if (lat == 0) begin
                mem_rdy   <= 1'b1;
                mem_rdata <= mrd(mem_addr);
                lat <= (rd_cnt + wr_cnt) % 3;
            end else lat <= lat - 1;
        end
    end

    // monitor: pops expected results as the design finishes
    always @(negedge clk) begin
        if (rsp_done) begin
            if (sbq.size() == 0) chk(0, "R12 unexpected done", 32'h1, 32'h0);
            else begin
                exp_t e;
                e = sbq.pop_front();
                chk(rsp_ra == e.ra, {e.tag, " ra"}, rsp_ra, e.ra);
                chk(rsp_fault == e.f, {e.tag, " fault"}, {30'h0, rsp_fault}, {30'h0, e.f});
            end
        end
    end

    function automatic logic [31:0] grp(input logic [23:0] vsid, input logic [15:0] pg, input bit sec);
        logic [18:0] h;
        h = vsid[18:0] ^ {3'b0, pg};
        if (sec) h = ~h;
        return {cfg_base | {7'b0, h[18:10] & cfg_mask}, h[9:0], 6'b0};
    endfunction

    function automatic logic [31:0] pte_w1a(input logic [23:0] vsid, input logic [15:0] pg, input bit sec, input int slot);
        return grp(vsid, pg, sec) + 32'(slot * 8) + 32'd4;
    endfunction

    function automatic void put(input logic [23:0] vsid, input logic [15:0] pg, input bit sec,
                                input int slot, input bit h, input logic [19:0] rpn,
                                input bit r, input bit c, input logic [1:0] pp);
        logic [31:0] a;
        a = grp(vsid, pg, sec) + 32'(slot * 8);
        mem[a]     = {1'b1, vsid, h, pg[15:10]};
        mem[a + 4] = {rpn, 3'b0, r, c, 5'b0, pp};
    endfunction

    task automatic seg_wr(input logic [3:0] i, input logic [31:0] d);
        @(negedge clk); seg_we = 1; seg_idx = i; seg_data = d;
        @(negedge clk); seg_we = 0;
    endtask

    task automatic xl(input logic [31:0] ea, input logic [1:0] acc, input bit usr,
                      input logic [31:0] e_ra, input logic [1:0] e_f,
                      input int e_rd, input int e_wr, input string tag);
        exp_t e;
        int r0, w0;
        e.ra = e_ra; e.f = e_f; e.tag = tag;
        sbq.push_back(e);
        @(negedge clk);
        r0 = rd_cnt; w0 = wr_cnt;
        req_valid = 1; req_ea = ea; req_acc = acc; req_user = usr;
        @(negedge clk);
        req_valid = 0;
        while (!rsp_done) @(negedge clk);
        chk(rd_cnt - r0 == e_rd, {tag, " reads"}, 32'(rd_cnt - r0), 32'(e_rd));
        chk(wr_cnt - w0 == e_wr, {tag, " writes"}, 32'(wr_cnt - w0), 32'(e_wr));
    endtask

    function automatic logic [31:0] ea_of(input logic [3:0] s, input logic [15:0] pg, input logic [11:0] off);
        return {s, pg, off};
    endfunction

    localparam logic [23:0] V1 = 24'h000123, V2 = 24'h000789, V3 = 24'h000456;
    localparam logic [15:0] P1 = 16'h0041, P2 = 16'h0C82, P3 = 16'h00C3,
                            P4 = 16'h0104, P5 = 16'h0145, P6 = 16'h0186;

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(rsp_done == 0, "R1 done after reset", {31'h0, rsp_done}, 0);
        chk(mem_req == 0, "R1 mem_req after reset", {31'h0, mem_req}, 0);

        seg_wr(4'd1, 32'h2000_0000 | 32'(V1)); // Ks=0 Kp=1
        seg_wr(4'd2, 32'h1000_0000 | 32'(V2)); // no-execute
        seg_wr(4'd3, 32'(V3));

        put(V1, P1, 0, 3, 0, 20'hAAAA1, 0, 0, 2'b10);
        put(V1, P2, 0, 5, 1, 20'hDEAD0, 1, 0, 2'b10);   // decoy, wrong hash select
        put(V1, P2, 1, 0, 1, 20'hBBBB2, 1, 0, 2'b10);
        put(V1, P4, 0, 0, 0, 20'hCCCC4, 0, 0, 2'b11);
        put(V1, P5, 0, 0, 0, 20'hDDDD5, 1, 0, 2'b00);
        put(V1, P6, 0, 0, 0, 20'hEEEE6, 0, 0, 2'b01);

        // R3 R6: primary slot 3, referenced written back
        xl(ea_of(1, P1, 12'h234), 0, 0, 32'hAAAA1234, 0, 5, 1, "R3 R1 primary walk");
        chk(mrd(pte_w1a(V1, P1, 0, 3))[8] == 1, "R6 referenced set", mrd(pte_w1a(V1, P1, 0, 3)), 32'h100);
        // R7 hit
        xl(ea_of(1, P1, 12'hFFC), 0, 0, 32'hAAAA1FFC, 0, 0, 0, "R7 hit");
        // R9 changed bit
        xl(ea_of(1, P1, 12'h010), 1, 0, 32'hAAAA1010, 0, 1, 1, "R9 first write");
        chk(mrd(pte_w1a(V1, P1, 0, 3))[7] == 1, "R9 changed set", mrd(pte_w1a(V1, P1, 0, 3)), 32'h180);
        xl(ea_of(1, P1, 12'h014), 1, 0, 32'hAAAA1014, 0, 0, 0, "R9 second write");
        // R4 secondary with decoy, R6 no write when referenced already set
        xl(ea_of(1, P2, 12'h008), 0, 0, 32'hBBBB2008, 0, 10, 0, "R4 secondary");
        // R5 miss
        xl(ea_of(1, P3, 12'h000), 0, 0, 32'h0, 1, 16, 0, "R5 miss");
        // R8 permissions
        xl(ea_of(1, P1, 12'h020), 0, 1, 32'hAAAA1020, 0, 0, 0, "R8 user read pp2");
        xl(ea_of(1, P1, 12'h024), 1, 1, 32'hAAAA1024, 0, 0, 0, "R8 user write pp2");
        xl(ea_of(1, P4, 12'h100), 0, 1, 32'hCCCC4100, 0, 2, 1, "R8 user read pp3");
        xl(ea_of(1, P4, 12'h104), 1, 1, 32'h0, 2, 0, 0, "R8 user write pp3");
        xl(ea_of(1, P4, 12'h108), 1, 0, 32'h0, 2, 0, 0, "R8 super write pp3");
        xl(ea_of(1, P4, 12'h10C), 2, 0, 32'hCCCC410C, 0, 0, 0, "R8 super fetch pp3");
        xl(ea_of(1, P5, 12'h200), 0, 1, 32'h0, 2, 2, 0, "R8 user read pp0");
        xl(ea_of(1, P5, 12'h204), 0, 0, 32'hDDDD5204, 0, 0, 0, "R8 super read pp0");
        xl(ea_of(1, P5, 12'h208), 2, 1, 32'h0, 2, 0, 0, "R8 user fetch pp0");
        xl(ea_of(1, P6, 12'h300), 0, 1, 32'hEEEE6300, 0, 2, 1, "R8 user read pp1");
        xl(ea_of(1, P6, 12'h304), 1, 1, 32'h0, 2, 0, 0, "R8 user write pp1");
        // R2 no-execute
        xl(ea_of(2, P1, 12'h000), 2, 0, 32'h0, 2, 0, 0, "R2 nx fetch");
        xl(ea_of(2, P1, 12'h000), 0, 0, 32'h0, 1, 16, 0, "R2 nx data read walks");
        // R7 VSID mismatch at same index
        xl(ea_of(3, P1, 12'h000), 0, 0, 32'h0, 1, 16, 0, "R7 vsid mismatch");
        // R10 invalidate
        @(negedge clk); inv_one = 1; inv_ea = ea_of(1, P1, 12'h0);
        @(negedge clk); inv_one = 0;
        xl(ea_of(1, P1, 12'h400), 0, 0, 32'hAAAA1400, 0, 5, 0, "R10 inv_one rewalk");
        xl(ea_of(1, P2, 12'h404), 0, 0, 32'hBBBB2404, 0, 0, 0, "R10 other entry kept");
        @(negedge clk); inv_all = 1;
        @(negedge clk); inv_all = 0;
        xl(ea_of(1, P2, 12'h408), 0, 0, 32'hBBBB2408, 0, 10, 0, "R10 inv_all rewalk");
        xl(ea_of(1, P1, 12'h40C), 1, 0, 32'hAAAA140C, 0, 5, 0, "R10 inv_all write cached C");

        repeat (3) @(negedge clk);
        chk(sbq.size() == 0, "R12 all results seen", 32'(sbq.size()), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule